// File: doc/BRIEF.md
# Fixed-Point Complex Multiplier with Requantized Partial Products

This block multiplies two complex operands. Each of the four components is a signed two's-complement fraction in the range -1 to just under +1. The block forms the four cross products. It cuts each one back to operand width, either by truncation or by round-half-up, and then combines them. The real result is the difference of the real-by-real and imaginary-by-imaginary terms. The imaginary result is the sum of the two mixed terms. Both results carry one extra integer bit, so the final add or subtract never overflows.

An operand pair is presented with a valid strobe and a quantization select. Two register stages follow: the requantized products, then the sum and the difference. A result therefore appears two cycles after its operands, flagged by an output valid. There is no back-pressure. When no result is arriving, the output registers keep their last contents.

Top module: `cmul_fp`

## Requirements
- R1: While reset is high, on each clock `out_valid` is cleared to 0 and `out_re` and `out_im` are cleared to 0.
- R2: `out_valid` is high in exactly those cycles that come two clocks after a cycle in which `in_valid` was high.
- R3: With `round_en` = 0, each 16-bit product p of two W=8 bit fractions is reduced to floor(p / 128), i.e. product bits [14:7]: the sign plus the seven most significant fraction bits, with the duplicate sign bit dropped.
- R4: With `round_en` = 1, each product is reduced to floor((p + 64) / 128), i.e. rounded to nearest with ties toward plus infinity.
- R5: The product (-1)·(-1), with both operands equal to code 0x80, is forced to the largest positive code 0x7F in both modes. All other products are unaffected.
- R6: `out_re` equals the requantized (a_re·b_re) minus the requantized (a_im·b_im), exactly, as a 9-bit signed value.
- R7: `out_im` equals the requantized (a_re·b_im) plus the requantized (a_im·b_re), exactly, as a 9-bit signed value.
- R8: `round_en` is used only in cycles where `in_valid` is high. Changing it while `in_valid` is low does not alter any result.
- R9: In any cycle where `out_valid` is low, `out_re` and `out_im` keep the values they had in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| round_en | input | 1 | 1 = round each product, 0 = truncate |
| a_re | input | 8 | Real part of operand A, signed fraction |
| a_im | input | 8 | Imaginary part of operand A, signed fraction |
| b_re | input | 8 | Real part of operand B, signed fraction |
| b_im | input | 8 | Imaginary part of operand B, signed fraction |
| out_valid | output | 1 | Result valid, two cycles after `in_valid` |
| out_re | output | 9 | Real part of the product, signed |
| out_im | output | 9 | Imaginary part of the product, signed |

## Verification
Saturation and rounding can land on the same product in the same cycle. When both operands are 0x80 and rounding is selected, the bias is added on top of the one product that already overflows. The bench drives all four components at 0x80 in both modes, expecting 0 for the real part and 254 for the imaginary part, and it also mixes 0x80 with other codes in random traffic. A behavioural integer model with a result queue judges every cycle, including the hold cycles between results.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

  // Quantization choice applied to every partial product
  typedef enum logic {
    QM_TRUNC = 1'b0,
    QM_ROUND = 1'b1
  } qmode_e;

  // Index of each cross product inside the product bank
  localparam int unsigned P_RR   = 0;  // a_re * b_re
  localparam int unsigned P_II   = 1;  // a_im * b_im
  localparam int unsigned P_RI   = 2;  // a_re * b_im
  localparam int unsigned P_IR   = 3;  // a_im * b_re
  localparam int unsigned NPROD  = 4;

endpackage

// File: rtl/cmul_requant.sv
// One signed fractional multiply reduced back to operand width.
module cmul_requant
  import cmul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic signed [W-1:0] x,
  input  logic signed [W-1:0] y,
  input  qmode_e              mode,
  output logic signed [W-1:0] q
);

  localparam int PW   = 2 * W;      // full product width
  localparam int SW   = PW + 1;     // product plus bias headroom
  localparam int LSB  = W - 1;      // first kept bit
  localparam int MSB  = PW - 2;     // last kept bit (duplicate sign dropped)

  logic signed [PW-1:0] prod;
  logic signed [SW-1:0] biased;
  logic signed [SW-1:0] bias;
  logic                 ovf;

  always_comb begin
    prod = x * y;
    bias = '0;
    if (mode == QM_ROUND) bias[LSB-1] = 1'b1;
    biased = $signed({prod[PW-1], prod}) + bias;
    // Kept field is [MSB:LSB]; overflow when the bit above disagrees with it
    ovf = biased[PW-1] ^ biased[MSB];
  end

  always_comb begin
    if (ovf) begin
      q = {1'b0, {(W-1){1'b1}}};
    end else begin
      q = biased[MSB:LSB];
    end
  end

endmodule

// File: rtl/cmul_prod_stage.sv
// First register stage: four requantized cross products.
module cmul_prod_stage
  import cmul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  qmode_e                     mode,
  input  logic signed [W-1:0]        a_re,
  input  logic signed [W-1:0]        a_im,
  input  logic signed [W-1:0]        b_re,
  input  logic signed [W-1:0]        b_im,
  output logic                       p_valid,
  output logic signed [NPROD-1:0][W-1:0] p_q
);

  logic signed [NPROD-1:0][W-1:0] opx;
  logic signed [NPROD-1:0][W-1:0] opy;
  logic signed [NPROD-1:0][W-1:0] q_next;

  always_comb begin
    opx[P_RR] = a_re;  opy[P_RR] = b_re;
    opx[P_II] = a_im;  opy[P_II] = b_im;
    opx[P_RI] = a_re;  opy[P_RI] = b_im;
    opx[P_IR] = a_im;  opy[P_IR] = b_re;
  end

  for (genvar k = 0; k < NPROD; k++) begin : g_mul
    cmul_requant #(.W(W)) u_rq (
      .x    (opx[k]),
      .y    (opy[k]),
      .mode (mode),
      .q    (q_next[k])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        p_q[k] <= '0;
      end else if (in_valid) begin
        p_q[k] <= q_next[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p_valid <= 1'b0;
    end else begin
      p_valid <= in_valid;
    end
  end

endmodule

// File: rtl/cmul_combine.sv
// Second register stage: widened difference and sum.
module cmul_combine
  import cmul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           p_valid,
  input  logic signed [NPROD-1:0][W-1:0] p_q,
  output logic                           out_valid,
  output logic signed [W:0]              out_re,
  output logic signed [W:0]              out_im
);

  logic signed [W:0] rr_x, ii_x, ri_x, ir_x;
  logic signed [W:0] re_next, im_next;

  always_comb begin
    rr_x    = {p_q[P_RR][W-1], p_q[P_RR]};
    ii_x    = {p_q[P_II][W-1], p_q[P_II]};
    ri_x    = {p_q[P_RI][W-1], p_q[P_RI]};
    ir_x    = {p_q[P_IR][W-1], p_q[P_IR]};
    re_next = rr_x - ii_x;
    im_next = ri_x + ir_x;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= p_valid;
      if (p_valid) begin
        out_re <= re_next;
        out_im <= im_next;
      end
    end
  end

endmodule

// File: rtl/cmul_fp.sv
module cmul_fp
  import cmul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                round_en,
  input  logic signed [W-1:0] a_re,
  input  logic signed [W-1:0] a_im,
  input  logic signed [W-1:0] b_re,
  input  logic signed [W-1:0] b_im,
  output logic                out_valid,
  output logic signed [W:0]   out_re,
  output logic signed [W:0]   out_im
);

  qmode_e                         mode;
  logic                           p_valid;
  logic signed [NPROD-1:0][W-1:0] p_q;

  assign mode = round_en ? QM_ROUND : QM_TRUNC;

  cmul_prod_stage #(.W(W)) u_prod (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .mode     (mode),
    .a_re     (a_re),
    .a_im     (a_im),
    .b_re     (b_re),
    .b_im     (b_im),
    .p_valid  (p_valid),
    .p_q      (p_q)
  );

  cmul_combine #(.W(W)) u_comb (
    .clk       (clk),
    .rst       (rst),
    .p_valid   (p_valid),
    .p_q       (p_q),
    .out_valid (out_valid),
    .out_re    (out_re),
    .out_im    (out_im)
  );

endmodule

// File: rtl/cmul_fp_chk.sv
module cmul_fp_chk #(
  parameter int W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                round_en,
  input logic signed [W-1:0] a_re,
  input logic signed [W-1:0] a_im,
  input logic signed [W-1:0] b_re,
  input logic signed [W-1:0] b_im,
  input logic                out_valid,
  input logic signed [W:0]   out_re,
  input logic signed [W:0]   out_im
);

  localparam int MAXC = (1 << (W - 1)) - 1;
  localparam int MINC = -(1 << (W - 1));

  logic [1:0] since;
  always_ff @(posedge clk) begin
    if (rst) since <= '0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  function automatic int rq(input int x, input int y, input logic rnd);
    int p;
    p = x * y;
    if (rnd) p = p + (1 << (W - 2));
    p = p >>> (W - 1);
    if (p > MAXC) p = MAXC;
    return p;
  endfunction

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && out_re == 0 && out_im == 0));

  a_r2_valid_lag: assert property (@(posedge clk) disable iff (rst)
    (since >= 2) |-> (out_valid == $past(in_valid, 2)));

  a_r6_real_part: assert property (@(posedge clk) disable iff (rst)
    (since >= 2 && out_valid) |->
      (int'(out_re) == rq(int'($past(a_re, 2)), int'($past(b_re, 2)), $past(round_en, 2))
                     - rq(int'($past(a_im, 2)), int'($past(b_im, 2)), $past(round_en, 2))));

  a_r7_imag_part: assert property (@(posedge clk) disable iff (rst)
    (since >= 2 && out_valid) |->
      (int'(out_im) == rq(int'($past(a_re, 2)), int'($past(b_im, 2)), $past(round_en, 2))
                     + rq(int'($past(a_im, 2)), int'($past(b_re, 2)), $past(round_en, 2))));

  a_r5_all_min_saturates: assert property (@(posedge clk) disable iff (rst)
    (since >= 2 && out_valid && int'($past(a_re, 2)) == MINC && int'($past(a_im, 2)) == MINC
      && int'($past(b_re, 2)) == MINC && int'($past(b_im, 2)) == MINC)
      |-> (int'(out_re) == 0 && int'(out_im) == 2 * MAXC));

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (since >= 1 && !out_valid) |-> ($stable(out_re) && $stable(out_im)));

endmodule

bind cmul_fp cmul_fp_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .round_en  (round_en),
  .a_re      (a_re),
  .a_im      (a_im),
  .b_re      (b_re),
  .b_im      (b_im),
  .out_valid (out_valid),
  .out_re    (out_re),
  .out_im    (out_im)
);

// File: tb/cmul_fp_tb.sv
module cmul_fp_tb;

  localparam int W = 8;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                in_valid = 1'b0;
  logic                round_en = 1'b0;
  logic signed [W-1:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
  logic                out_valid;
  logic signed [W:0]   out_re, out_im;

  int    n_run  = 0;
  int    n_fail = 0;
  bit    active = 1'b0;
  bit    done   = 1'b0;
  string phase  = "R3";

  always #5 clk = ~clk;

  cmul_fp #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .round_en(round_en),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  // Requantization per R3/R4/R5 in plain integer arithmetic
  function automatic int qz(input int x, input int y, input bit rnd);
    int p;
    p = x * y;
    if (rnd) p += 64;
    if (p >= 0) p = p / 128;
    else p = -((-p + 127) / 128);
    if (p > 127) p = 127;
    return p;
  endfunction

  // Behavioural reference: valid history plus a queue of expected results
  int exp_re_q[$];
  int exp_im_q[$];
  bit ev1 = 1'b0, ev2 = 1'b0;
  int held_re = 0, held_im = 0;

  always @(posedge clk) begin
    if (rst) begin
      ev1 = 1'b0; ev2 = 1'b0;
      exp_re_q.delete(); exp_im_q.delete();
      held_re = 0; held_im = 0;
    end else begin
      ev2 = ev1;
      ev1 = in_valid;
      if (in_valid) begin
        exp_re_q.push_back(qz(a_re, b_re, round_en) - qz(a_im, b_im, round_en));
        exp_im_q.push_back(qz(a_re, b_im, round_en) + qz(a_im, b_re, round_en));
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s [%s]: actual %0d expected %0d at %0t", tag, phase, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (active && !rst) begin
      chk(out_valid == ev2, "R2", int'(out_valid), int'(ev2));
      if (ev2 && exp_re_q.size() > 0) begin
        held_re = exp_re_q.pop_front();
        held_im = exp_im_q.pop_front();
        chk(int'(out_re) == held_re, "R6", int'(out_re), held_re);
        chk(int'(out_im) == held_im, "R7", int'(out_im), held_im);
      end else begin
        chk(int'(out_re) == held_re, "R9", int'(out_re), held_re);
        chk(int'(out_im) == held_im, "R9", int'(out_im), held_im);
      end
    end
  end

  task automatic send(input int ar, input int ai, input int br, input int bi, input bit rnd);
    @(posedge clk); #1;
    in_valid = 1'b1; round_en = rnd;
    a_re = W'(ar); a_im = W'(ai); b_re = W'(br); b_im = W'(bi);
  endtask

  task automatic idle(input int n, input bit toggle_mode);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b0;
      if (toggle_mode) round_en = ~round_en;
      a_re = W'($urandom); b_im = W'($urandom);
    end
  endtask

  // Watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <= 100000 cycles", wd);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    // R1: state held in reset
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    chk(out_re == 0, "R1", int'(out_re), 0);
    chk(out_im == 0, "R1", int'(out_im), 0);
    rst = 1'b0;
    active = 1'b1;

    // R3: truncation, mixed signs, back to back
    phase = "R3";
    send(64, 32, 64, -32, 0);
    send(-1, 1, 127, -127, 0);
    send(-128, 127, 1, -1, 0);
    send(3, -3, 85, 43, 0);
    idle(3, 0);

    // R4: rounding on the same patterns
    phase = "R4";
    send(64, 32, 64, -32, 1);
    send(-1, 1, 127, -127, 1);
    send(-128, 127, 1, -1, 1);
    send(3, -3, 85, 43, 1);
    idle(3, 0);

    // R5: -1 * -1 saturation, alone and with rounding in the same cycle
    phase = "R5";
    send(-128, -128, -128, -128, 0);
    send(-128, -128, -128, -128, 1);
    send(-128, 0, -128, 127, 1);
    idle(3, 0);

    // R8: mode changes while idle must not disturb in-flight results
    phase = "R8";
    send(5, -7, 99, -33, 1);
    idle(4, 1);
    send(5, -7, 99, -33, 0);
    idle(4, 1);

    // R9: gaps between results, outputs must hold
    phase = "R9";
    send(100, -100, -50, 77, 1);
    idle(5, 0);
    send(-90, 60, 120, -128, 0);
    idle(5, 0);

    // Random traffic covering all requirements together
    phase = "RND";
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 3) != 0)
        send($urandom, $urandom, $urandom, $urandom, 1'($urandom));
      else
        idle(1, 1'($urandom));
    end
    idle(4, 0);

    // R1: reset in the middle of traffic clears the outputs
    phase = "R1";
    send(127, 127, 127, 127, 1);
    @(posedge clk); #1;
    in_valid = 1'b0;
    active = 1'b0;
    rst = 1'b1;
    @(posedge clk); #1;
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    chk(out_re == 0, "R1", int'(out_re), 0);
    chk(out_im == 0, "R1", int'(out_im), 0);
    @(posedge clk); #1;
    rst = 1'b0;
    active = 1'b1;
    idle(4, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule